// File: doc/BRIEF.md
# Packet-Command Task-File Interrupt Controller

This block is the device end of a packet-command disk interface. It holds the byte-wide task-file registers that the host writes through a small register port: feature, sector count, three address bytes, device, command, and device control. It reports status back through the same port. Register writes are refused while the device is busy or has data pending. Command writes execute at once. The packet opcode opens a six-word data phase that collects a 12-byte command packet and hands it to the device logic with a one-cycle done pulse.

The device side answers with a PIO read reply. It announces the byte count, and the block publishes that count in the address-mid and address-high registers. The block then streams 16-bit words from a simple word source, one word per host data read. The reply is split into blocks whose size is the value the host wrote into the same two registers before the reply began. An interrupt is requested at every block boundary except the end of the transfer.

The interrupt logic keeps one pending flag. A level line follows that flag, masked live by the device-control disable bit. The block also drives two single-cycle event pulses that tell an external interrupt multiplexer to set or withdraw the event. Only a status read taken while the device is not busy clears the flag. A command write also clears it.

Top module: `pkt_taskfile_ctrl`

## Requirements
- R1: Register selects are 0 data, 1 error (read) / feature (write), 2 count, 3 address-low, 4 address-mid, 5 address-high, 6 device, 7 status (read) / command (write), 8 alternate status (read) / device control (write). Byte registers read back zero-extended on 16 bits. After reset, error reads 0x01, count 0x01, address-low 0x81, address-mid 0x14, address-high 0xEB, device 0x00, status 0x00, feature output 0x00, and the interrupt line is low.
- R2: Writes to feature, count, the three address bytes, device and command take effect only when status bit 7 (busy, mirrored from `busy_i`) and status bit 3 (data request) are both 0. Otherwise they change nothing.
- R3: Device-control bit 1 disables the interrupt. While an interrupt is pending, setting the bit gives one clear pulse and drops the line, and clearing it gives one raise pulse and lifts the line. Without a pending interrupt, device-control writes give no pulse.
- R4: A status read (select 7) while `busy_i` is 0 clears the pending interrupt. A status read while busy, or any alternate-status read (select 8), leaves it pending.
- R5: An accepted command write clears any pending interrupt and sets status bits 6 and 4, so a fresh status reads 0x50. The opcode 0xA0 also sets status bit 3.
- R6: After opcode 0xA0, six data writes fill the packet. Word k occupies bits 16k+15..16k of `pkt_o`. The sixth write clears bit 3, pulses `pkt_done_o` and raises the interrupt in the same cycle.
- R7: A reply start accepted while bit 3 is 0 loads the byte count into address-mid (low byte) and address-high (high byte). It sets bit 3, and takes as block size the address-mid/address-high value held just before the start.
- R8: During a reply, each data read returns `rep_data_i`, pulses `rep_rd_o`, and lowers the remaining total and the remaining block by 2. When 2 or fewer bytes remained, bit 3 clears. Otherwise, when 2 or fewer block bytes remained, an interrupt is raised and the block count reloads.
- R9: A data read with no reply active returns 0xFFFF, gives no `rep_rd_o` pulse and changes no state.
- R10: An error input sets status to 0x51, loads the error register with the given code (0x50 for a missing medium) and ends any data phase.
- R11: Raising while pending and clearing while not pending have no effect. Raise and clear pulses last one cycle, occur only while the interrupt is enabled, and never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Host register write strobe |
| reg_rd_i | input | 1 | Host register read strobe (side effects) |
| reg_sel_i | input | 4 | Register select |
| reg_wdata_i | input | 16 | Host write data |
| reg_rdata_o | output | 16 | Host read data for the current select |
| busy_i | input | 1 | Device busy, shown as status bit 7 |
| err_i | input | 1 | Device error strobe |
| err_code_i | input | 8 | Error code loaded on `err_i` |
| rep_start_i | input | 1 | Start a PIO read reply |
| rep_len_i | input | 16 | Reply length in bytes |
| rep_data_i | input | 16 | Current reply word |
| rep_rd_o | output | 1 | Reply word consumed this cycle |
| pkt_o | output | PKT_BYTES*8 | Received command packet |
| pkt_done_o | output | 1 | One-cycle pulse when the packet is complete |
| feature_o | output | 8 | Feature register |
| irq_o | output | 1 | Interrupt line (pending and enabled) |
| evt_raise_o | output | 1 | One-cycle pulse: assert interrupt event |
| evt_clear_o | output | 1 | One-cycle pulse: withdraw interrupt event |

## Verification
The bench sweeps reply lengths of 1 to 16 bytes against block sizes of 2 to 8. Each sweep point is checked word by word. A counter that compared below zero rather than at 2 or fewer would raise an interrupt on the final word or hold data request one word too long. A block size sampled after the length overwrite would put boundaries in the wrong place. Separate cases cover the interrupt rules:
- toggling the disable bit while pending, where a design without live masking would leave the line up or skip the re-raise pulse;
- status reads under busy, and alternate-status reads, where a careless clear would lose the interrupt;
- a block boundary hit while already pending, where a second raise pulse would double-count the event.

// File: rtl/pkt_tf_pkg.sv
package pkt_tf_pkg;
  typedef enum logic [3:0] {
    SEL_DATA    = 4'd0,
    SEL_ERRFEAT = 4'd1,
    SEL_COUNT   = 4'd2,
    SEL_LBA_LO  = 4'd3,
    SEL_LBA_MID = 4'd4,
    SEL_LBA_HI  = 4'd5,
    SEL_DEV     = 4'd6,
    SEL_STATCMD = 4'd7,
    SEL_ALTCTL  = 4'd8
  } tf_sel_e;

  localparam int ST_BUSY     = 7;
  localparam int ST_DRQ      = 3;
  localparam int CTL_DIS_BIT = 1;
  localparam logic [7:0] ST_CMD_DONE = 8'h50;
  localparam logic [7:0] ST_ERROR    = 8'h51;

  typedef struct packed {
    logic [7:0] err;
    logic [7:0] cnt;
    logic [7:0] lba_lo;
    logic [7:0] lba_mid;
    logic [7:0] lba_hi;
    logic [7:0] dev;
    logic [7:0] feat;
  } tf_regs_t;

  localparam tf_regs_t TF_RESET = '{err: 8'h01, cnt: 8'h01, lba_lo: 8'h81,
                                    lba_mid: 8'h14, lba_hi: 8'hEB,
                                    dev: 8'h00, feat: 8'h00};
endpackage

// File: rtl/tf_irq_ctrl.sv
module tf_irq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raise_req_i,
  input  logic clear_req_i,
  input  logic ctl_wr_i,
  input  logic ctl_dis_i,
  output logic pending_o,
  output logic irq_o,
  output logic raise_o,
  output logic clear_o
);
  logic dis_q, pend_q, raise_q, clear_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q   <= 1'b0;
      pend_q  <= 1'b0;
      raise_q <= 1'b0;
      clear_q <= 1'b0;
    end else begin
      raise_q <= 1'b0;
      clear_q <= 1'b0;
      if (ctl_wr_i) begin
        // mask change replays the pending state to the event side
        dis_q <= ctl_dis_i;
        if (pend_q && !dis_q && ctl_dis_i)  clear_q <= 1'b1;
        if (pend_q && dis_q && !ctl_dis_i)  raise_q <= 1'b1;
      end else if (clear_req_i) begin
        if (pend_q) begin
          pend_q  <= 1'b0;
          clear_q <= !dis_q;
        end
      end else if (raise_req_i) begin
        if (!pend_q) begin
          pend_q  <= 1'b1;
          raise_q <= !dis_q;
        end
      end
    end
  end

  assign pending_o = pend_q;
  assign irq_o     = pend_q & ~dis_q;
  assign raise_o   = raise_q;
  assign clear_o   = clear_q;
endmodule

// File: rtl/tf_pkt_rx.sv
module tf_pkt_rx #(
  parameter int PKT_WORDS = 6,
  parameter int WORD_W    = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic                          abort_i,
  input  logic                          wr_i,
  input  logic [WORD_W-1:0]             wdata_i,
  output logic                          active_o,
  output logic                          last_o,
  output logic                          done_o,
  output logic [PKT_WORDS*WORD_W-1:0]   pkt_o
);
  localparam int CNT_W = $clog2(PKT_WORDS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PKT_WORDS - 1);

  logic             active_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic             take;

  assign take   = wr_i & active_q;
  assign last_o = take & (cnt_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        active_q <= 1'b0;
      end else if (start_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (take) begin
        cnt_q <= cnt_q + 1'b1;
        if (last_o) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < PKT_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              word_q <= '0;
      else if (take && cnt_q == CNT_W'(g))      word_q <= wdata_i;
    end
    assign pkt_o[g*WORD_W +: WORD_W] = word_q;
  end

  assign active_o = active_q;
  assign done_o   = done_q;
endmodule

// File: rtl/tf_xfer_cnt.sv
module tf_xfer_cnt #(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             abort_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] bsize_i,
  input  logic             step_i,
  output logic             active_o,
  output logic             blk_hit_o
);
  localparam logic [LEN_W-1:0] STEP = LEN_W'(2);

  logic             active_q;
  logic [LEN_W-1:0] total_q, blk_q, bsize_q;
  logic             final_word;

  assign final_word = total_q <= STEP;
  assign blk_hit_o  = step_i & active_q & ~final_word & (blk_q <= STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      total_q  <= '0;
      blk_q    <= '0;
      bsize_q  <= '0;
    end else if (abort_i) begin
      active_q <= 1'b0;
    end else if (load_i) begin
      active_q <= 1'b1;
      total_q  <= len_i;
      blk_q    <= bsize_i;
      bsize_q  <= bsize_i;
    end else if (step_i && active_q) begin
      if (final_word) begin
        active_q <= 1'b0;
      end else begin
        total_q <= total_q - STEP;
        blk_q   <= (blk_q <= STEP) ? bsize_q : blk_q - STEP;
      end
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/pkt_taskfile_ctrl.sv
module pkt_taskfile_ctrl
  import pkt_tf_pkg::*;
#(
  parameter int         PKT_BYTES  = 12,
  parameter logic [7:0] PKT_OPCODE = 8'hA0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   reg_wr_i,
  input  logic                   reg_rd_i,
  input  logic [3:0]             reg_sel_i,
  input  logic [15:0]            reg_wdata_i,
  output logic [15:0]            reg_rdata_o,
  input  logic                   busy_i,
  input  logic                   err_i,
  input  logic [7:0]             err_code_i,
  input  logic                   rep_start_i,
  input  logic [15:0]            rep_len_i,
  input  logic [15:0]            rep_data_i,
  output logic                   rep_rd_o,
  output logic [PKT_BYTES*8-1:0] pkt_o,
  output logic                   pkt_done_o,
  output logic [7:0]             feature_o,
  output logic                   irq_o,
  output logic                   evt_raise_o,
  output logic                   evt_clear_o
);
  localparam int PKT_WORDS = PKT_BYTES / 2;
  localparam int LEN_W     = 16;

  tf_regs_t regs_q;
  logic [7:0] stat_q;
  logic [7:0] status;
  tf_sel_e    sel;
  logic pkt_active, pkt_last, xfer_active, blk_hit, drq, wr_ok;
  logic cmd_wr, ctl_wr, stat_rd, data_wr, data_rd, pkt_start, rep_load;
  logic raise_req, clear_req, irq_pending;

  assign sel       = tf_sel_e'(reg_sel_i);
  assign drq       = pkt_active | xfer_active;
  assign wr_ok     = ~busy_i & ~drq;
  assign status    = {busy_i, stat_q[6:4], drq, stat_q[2:0]};

  assign cmd_wr    = reg_wr_i & (sel == SEL_STATCMD) & wr_ok;
  assign ctl_wr    = reg_wr_i & (sel == SEL_ALTCTL);
  assign stat_rd   = reg_rd_i & (sel == SEL_STATCMD);
  assign data_wr   = reg_wr_i & (sel == SEL_DATA);
  assign data_rd   = reg_rd_i & (sel == SEL_DATA) & xfer_active;
  assign pkt_start = cmd_wr & (reg_wdata_i[7:0] == PKT_OPCODE);
  assign rep_load  = rep_start_i & ~drq & ~err_i;

  assign clear_req = cmd_wr | (stat_rd & ~busy_i);
  assign raise_req = pkt_last | blk_hit;
  assign rep_rd_o  = data_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= TF_RESET;
      stat_q <= '0;
    end else begin
      if (reg_wr_i && wr_ok) begin
        unique case (sel)
          SEL_ERRFEAT: regs_q.feat    <= reg_wdata_i[7:0];
          SEL_COUNT:   regs_q.cnt     <= reg_wdata_i[7:0];
          SEL_LBA_LO:  regs_q.lba_lo  <= reg_wdata_i[7:0];
          SEL_LBA_MID: regs_q.lba_mid <= reg_wdata_i[7:0];
          SEL_LBA_HI:  regs_q.lba_hi  <= reg_wdata_i[7:0];
          SEL_DEV:     regs_q.dev     <= reg_wdata_i[7:0];
          SEL_STATCMD: stat_q         <= stat_q | ST_CMD_DONE;
          default: ;
        endcase
      end
      if (rep_load) begin
        regs_q.lba_mid <= rep_len_i[7:0];
        regs_q.lba_hi  <= rep_len_i[15:8];
      end
      if (err_i) begin
        stat_q     <= ST_ERROR;
        regs_q.err <= err_code_i;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (sel)
      SEL_DATA:    reg_rdata_o = xfer_active ? rep_data_i : 16'hFFFF;
      SEL_ERRFEAT: reg_rdata_o = {8'h00, regs_q.err};
      SEL_COUNT:   reg_rdata_o = {8'h00, regs_q.cnt};
      SEL_LBA_LO:  reg_rdata_o = {8'h00, regs_q.lba_lo};
      SEL_LBA_MID: reg_rdata_o = {8'h00, regs_q.lba_mid};
      SEL_LBA_HI:  reg_rdata_o = {8'h00, regs_q.lba_hi};
      SEL_DEV:     reg_rdata_o = {8'h00, regs_q.dev};
      SEL_STATCMD,
      SEL_ALTCTL:  reg_rdata_o = {8'h00, status};
      default:     reg_rdata_o = '0;
    endcase
  end

  tf_pkt_rx #(.PKT_WORDS(PKT_WORDS), .WORD_W(16)) u_pkt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (pkt_start),
    .abort_i  (err_i),
    .wr_i     (data_wr),
    .wdata_i  (reg_wdata_i),
    .active_o (pkt_active),
    .last_o   (pkt_last),
    .done_o   (pkt_done_o),
    .pkt_o    (pkt_o)
  );

  tf_xfer_cnt #(.LEN_W(LEN_W)) u_xfer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (rep_load),
    .abort_i   (err_i),
    .len_i     (rep_len_i),
    .bsize_i   ({regs_q.lba_hi, regs_q.lba_mid}),
    .step_i    (data_rd),
    .active_o  (xfer_active),
    .blk_hit_o (blk_hit)
  );

  tf_irq_ctrl u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .raise_req_i (raise_req),
    .clear_req_i (clear_req),
    .ctl_wr_i    (ctl_wr),
    .ctl_dis_i   (reg_wdata_i[CTL_DIS_BIT]),
    .pending_o   (irq_pending),
    .irq_o       (irq_o),
    .raise_o     (evt_raise_o),
    .clear_o     (evt_clear_o)
  );

  assign feature_o = regs_q.feat;
endmodule

// File: rtl/pkt_taskfile_chk.sv
module pkt_taskfile_chk
  import pkt_tf_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_wr_i,
  input logic        reg_rd_i,
  input logic [3:0]  reg_sel_i,
  input logic        ctl_dis_wr,
  input logic [15:0] reg_rdata_o,
  input logic        busy_i,
  input logic        drq,
  input logic        rep_rd_o,
  input logic        pkt_done_o,
  input logic        pending,
  input logic [7:0]  cnt_q,
  input logic        irq_o,
  input logic        evt_raise_o,
  input logic        evt_clear_o
);
  // R11
  no_dual_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_raise_o && evt_clear_o));

  // R11
  raise_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_raise_o |-> irq_o);

  // R11
  clear_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_clear_o |-> !irq_o);

  // R3
  ctl_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_sel_i == SEL_ALTCTL && ctl_dis_wr) |=> !irq_o);

  // R4
  stat_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_sel_i == SEL_STATCMD && !busy_i) |=> !pending);

  // R4
  alt_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_sel_i == SEL_ALTCTL && pending) |=> pending);

  // R2
  gate_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_sel_i == SEL_COUNT && (busy_i || drq)) |=> $stable(cnt_q));

  // R9
  idle_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_sel_i == SEL_DATA && !drq) |-> (reg_rdata_o == 16'hFFFF && !rep_rd_o));

  // R6
  pkt_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_done_o |-> pending);
endmodule

bind pkt_taskfile_ctrl pkt_taskfile_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_sel_i   (reg_sel_i),
  .ctl_dis_wr  (reg_wdata_i[1]),
  .reg_rdata_o (reg_rdata_o),
  .busy_i      (busy_i),
  .drq         (drq),
  .rep_rd_o    (rep_rd_o),
  .pkt_done_o  (pkt_done_o),
  .pending     (irq_pending),
  .cnt_q       (regs_q.cnt),
  .irq_o       (irq_o),
  .evt_raise_o (evt_raise_o),
  .evt_clear_o (evt_clear_o)
);

// File: tb/pkt_taskfile_ctrl_test.sv
module pkt_taskfile_ctrl_test;
  localparam logic [3:0] S_DATA = 4'd0, S_ERR = 4'd1, S_CNT = 4'd2, S_LLO = 4'd3,
                         S_LMID = 4'd4, S_LHI = 4'd5, S_DEV = 4'd6, S_STAT = 4'd7,
                         S_ALT = 4'd8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] sel = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic busy = 1'b0, err = 1'b0;
  logic [7:0] err_code = '0;
  logic rep_start = 1'b0;
  logic [15:0] rep_len = '0;
  logic [15:0] rep_data;
  logic rep_rd;
  logic [95:0] pkt;
  logic pkt_done, irq, ev_raise, ev_clear;
  logic [7:0] feature;

  int n_chk = 0, n_fail = 0;
  int n_raise = 0, n_clear = 0, n_done = 0, n_word = 0;
  logic done_flag = 1'b0;

  always #2 clk = ~clk;

  pkt_taskfile_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .busy_i(busy), .err_i(err), .err_code_i(err_code),
    .rep_start_i(rep_start), .rep_len_i(rep_len), .rep_data_i(rep_data),
    .rep_rd_o(rep_rd), .pkt_o(pkt), .pkt_done_o(pkt_done), .feature_o(feature),
    .irq_o(irq), .evt_raise_o(ev_raise), .evt_clear_o(ev_clear)
  );

  assign rep_data = 16'hC000 + 16'(n_word);

  always @(posedge clk) begin
    if (ev_raise) n_raise++;
    if (ev_clear) n_clear++;
    if (pkt_done) n_done++;
    if (rep_rd)   n_word++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; sel = s; wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [15:0] d);
    @(negedge clk); reg_rd = 1'b1; sel = s; #1; d = rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [3:0] s, output logic [15:0] d);
    @(negedge clk); sel = s; #1; d = rdata;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic start_reply(input logic [15:0] len);
    @(negedge clk); rep_start = 1'b1; rep_len = len;
    @(negedge clk); rep_start = 1'b0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    int r0, c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R1 reset values (reads of data regs have no side effects)
    rd(S_ERR, v);  check("R1 error", v, 16'h0001);
    rd(S_CNT, v);  check("R1 count", v, 16'h0001);
    rd(S_LLO, v);  check("R1 lba_lo", v, 16'h0081);
    rd(S_LMID, v); check("R1 lba_mid", v, 16'h0014);
    rd(S_LHI, v);  check("R1 lba_hi", v, 16'h00EB);
    rd(S_DEV, v);  check("R1 device", v, 16'h0000);
    rd(S_ALT, v);  check("R1 status", v, 16'h0000);
    check("R1 feature", feature, 8'h00);
    check("R1 irq", irq, 1'b0);

    // R2 writes accepted when idle, refused while busy
    wr(S_CNT, 16'h0022); wr(S_DEV, 16'h00A5); wr(S_ERR, 16'h0003);
    rd(S_CNT, v); check("R2 count write", v, 16'h0022);
    rd(S_DEV, v); check("R2 device write", v, 16'h00A5);
    check("R2 feature write", feature, 8'h03);
    busy = 1'b1;
    wr(S_CNT, 16'h0033); wr(S_ERR, 16'h0007);
    rd(S_CNT, v); check("R2 count gated by busy", v, 16'h0022);
    check("R2 feature gated by busy", feature, 8'h03);
    rd(S_ALT, v); check("R2 busy shown in status", v, 16'h0080);
    wr(S_STAT, 16'h00A0);
    rd(S_ALT, v); check("R2 command gated by busy", v, 16'h0080);
    busy = 1'b0;
    wr(S_LMID, 16'h0008); wr(S_LHI, 16'h0000);

    // R5 packet command
    r0 = n_raise;
    wr(S_STAT, 16'h00A0);
    rd(S_ALT, v); check("R5 status after packet cmd", v, 16'h0058);
    wr(S_CNT, 16'h0077);
    rd(S_CNT, v); check("R2 count gated by drq", v, 16'h0022);

    // R6 packet reception
    for (int k = 0; k < 5; k++) wr(S_DATA, 16'h1111 * 16'(k + 1));
    tick();
    check("R6 no irq before last word", n_raise - r0, 0);
    wr(S_DATA, 16'h6666);
    tick();
    check("R6 raise pulse", n_raise - r0, 1);
    check("R6 done pulse", n_done, 1);
    check("R6 irq line", irq, 1'b1);
    rd(S_ALT, v); check("R6 drq cleared", v, 16'h0050);
    for (int k = 0; k < 6; k++)
      check("R6 packet word", pkt[16*k +: 16], 16'h1111 * 16'(k + 1));

    // R4 alternate status keeps pending
    check("R4 alt read keeps irq", irq, 1'b1);

    // R3 mask toggling while pending
    c0 = n_clear; r0 = n_raise;
    wr(S_ALT, 16'h0002); tick();
    check("R3 irq masked", irq, 1'b0);
    check("R3 clear pulse on mask", n_clear - c0, 1);
    wr(S_ALT, 16'h0000); tick();
    check("R3 irq unmasked", irq, 1'b1);
    check("R3 raise pulse on unmask", n_raise - r0, 1);

    // R4 status read under busy keeps, idle read clears
    busy = 1'b1;
    rd(S_STAT, v); tick();
    check("R4 busy status read keeps irq", irq, 1'b1);
    busy = 1'b0;
    c0 = n_clear;
    rd(S_STAT, v); tick();
    check("R4 status read clears irq", irq, 1'b0);
    check("R4 clear pulse", n_clear - c0, 1);
    // R11 clear with nothing pending
    rd(S_STAT, v); tick();
    check("R11 no clear pulse when idle", n_clear - c0, 1);
    r0 = n_raise;
    wr(S_ALT, 16'h0002); wr(S_ALT, 16'h0000); tick();
    check("R3 no pulses without pending", (n_raise - r0) + (n_clear - c0), 1);

    // R5 command write clears pending
    wr(S_STAT, 16'h00A0);
    for (int k = 0; k < 6; k++) wr(S_DATA, 16'h0101);
    tick();
    check("R6 second packet irq", irq, 1'b1);
    c0 = n_clear;
    wr(S_STAT, 16'h0000); tick();
    check("R5 command clears irq", irq, 1'b0);
    check("R5 clear pulse", n_clear - c0, 1);
    rd(S_ALT, v); check("R5 status after plain cmd", v, 16'h0050);

    // R11 disabled interrupt gives no pulses
    wr(S_ALT, 16'h0002);
    r0 = n_raise;
    wr(S_STAT, 16'h00A0);
    for (int k = 0; k < 6; k++) wr(S_DATA, 16'h0202);
    tick();
    check("R11 no raise while disabled", n_raise - r0, 0);
    check("R11 line low while disabled", irq, 1'b0);
    wr(S_ALT, 16'h0000); tick();
    check("R3 deferred raise", n_raise - r0, 1);
    rd(S_STAT, v);

    // R9 idle data read
    c0 = n_word;
    rd(S_DATA, v); tick();
    check("R9 idle read value", v, 16'hFFFF);
    check("R9 no word consumed", n_word - c0, 0);
    rd(S_ALT, v); check("R9 status unchanged", v, 16'h0050);

    // R7 R8 sweep over length and block size
    for (int bs = 2; bs <= 8; bs += 2) begin
      for (int len = 1; len <= 16; len++) begin
        int nw, w0;
        nw = (len + 1) / 2;
        wr(S_LMID, 16'(bs)); wr(S_LHI, 16'h0000);
        start_reply(16'(len));
        rd(S_LMID, v); check("R7 length low byte", v, 16'(len));
        rd(S_LHI, v);  check("R7 length high byte", v, 16'h0000);
        rd(S_ALT, v);  check("R7 drq set", v, 16'h0058);
        w0 = n_word;
        for (int i = 1; i <= nw; i++) begin
          logic exp_irq;
          rd(S_DATA, v);
          check("R8 word value", v, 16'hC000 + 16'(w0 + i - 1));
          exp_irq = (i < nw) && (i % (bs / 2) == 0);
          check("R8 block irq", irq, exp_irq);
          if (exp_irq) rd(S_STAT, v);
        end
        tick();
        check("R8 words consumed", n_word - w0, nw);
        rd(S_ALT, v); check("R8 drq cleared", v, 16'h0050);
      end
    end

    // R11 block boundary while pending: one raise only
    wr(S_LMID, 16'h0004); wr(S_LHI, 16'h0000);
    start_reply(16'h0010);
    r0 = n_raise;
    for (int i = 0; i < 8; i++) rd(S_DATA, v);
    tick();
    check("R11 single raise while pending", n_raise - r0, 1);
    check("R11 irq still pending", irq, 1'b1);
    rd(S_STAT, v);

    // R7 larger length uses high byte
    wr(S_LMID, 16'h0000); wr(S_LHI, 16'h0001);
    start_reply(16'h0123);
    rd(S_LMID, v); check("R7 big length low", v, 16'h0023);
    rd(S_LHI, v);  check("R7 big length high", v, 16'h0001);

    // R10 error aborts transfer
    rd(S_DATA, v);
    @(negedge clk); err = 1'b1; err_code = 8'h50;
    @(negedge clk); err = 1'b0;
    rd(S_ALT, v); check("R10 error status", v, 16'h0051);
    rd(S_ERR, v); check("R10 error code", v, 16'h0050);
    c0 = n_word;
    rd(S_DATA, v); tick();
    check("R10 data phase ended", v, 16'hFFFF);
    check("R10 no word after error", n_word - c0, 0);

    finish_run();
  end
endmodule